// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a single-port synchronous static RAM with a built-in four-beat burst address generator and write control at byte-lane granularity. The rising clock edge captures the address, the write data and the control inputs. The output-enable, sleep and order-select inputs act without waiting for a clock. Reads are flow-through: once an edge has fixed the current address, the word stored there appears on the read port in the same cycle, with no output register in the path. With the default parameters the word is 36 bits wide, split into four 9-bit lanes, and there are 256 words.

A burst can start from either of two strobes, and the two follow different rules. The processor strobe starts a read burst and takes priority, but it is ignored while the chip enable is inactive. The controller strobe starts a burst only when the processor strobe is not in effect. It also qualifies the cycle with the write controls, and if the chip enable is inactive it deselects the device instead.

Between starts, the advance input steps a two-bit beat counter. The burst goes either in linear order or in interleaved order, chosen by a static select input. Writes can target single lanes, all lanes through the write enable, or all lanes through the global write. A sleep input freezes the device, turns its outputs off and keeps the array contents.

Top module: `fts_burst_sram`

## Requirements
- R1: While reset is active and after it is released, the device is deselected: `dq_drive` is 0 and `dq_out` is 0.
- R2: An edge where `ce_n`=0 and `cpu_start_n`=0 loads `addr` as the burst base, resets the beat count and selects the device. The write controls are ignored on that edge.
- R3: When `ce_n`=1, `cpu_start_n` has no effect. If `ctl_start_n`=1 and `adv_n`=1 on that edge, the current address, the selection and the output all stay as they were.
- R4: An edge where `ctl_start_n`=0, and the processor strobe is not in effect, loads `addr` and selects the device when `ce_n`=0. On that same edge the word at `addr` is written according to the write controls.
- R5: In linear order (`order_ilv`=0), beat k of a burst at base b addresses `{b[7:2], (b[1:0]+k) mod 4}`. After four advances the burst wraps back to the base.
- R6: In interleaved order (`order_ilv`=1), beat k of a burst at base b addresses `{b[7:2], b[1:0] XOR (k mod 4)}`.
- R7: The beat count advances only on an edge with `adv_n`=0 and no burst start. A start on the same edge wins, and with `adv_n`=1 the address holds.
- R8: Lane i (bits `9*i+8 : 9*i`) is written when `wr_en_n`=0 and `lane_sel_n[i]`=0. Unselected lanes keep their contents. With `wr_en_n`=1 and `glob_wr_n`=1 nothing is written.
- R9: `glob_wr_n`=0 writes all four lanes, whatever `lane_sel_n` and `wr_en_n` hold.
- R10: On an edge that continues a selected burst, a write goes to the address that the edge produces, which is the advanced address when `adv_n`=0. Other words are not touched.
- R11: `dq_out` shows the array word at the current address in the same cycle that the edge sets that address. `oe_n`=1 forces `dq_drive` to 0 and `dq_out` to 0 at once, with no clock edge needed.
- R12: An edge where `ctl_start_n`=0 and `ce_n`=1 deselects the device. The output is still driven before that edge and is off (`dq_drive`=0, `dq_out`=0) right after it.
- R13: While `sleep`=1, edges change no state and write nothing, and the outputs are off. Once sleep ends, the previous address and data are visible again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | ADDR_W | External word address |
| ce_n | input | 1 | Chip enable, active low |
| cpu_start_n | input | 1 | Processor burst strobe, active low, read-only start, highest priority |
| ctl_start_n | input | 1 | Controller burst strobe, active low, qualified by write controls |
| adv_n | input | 1 | Burst advance, active low |
| wr_en_n | input | 1 | Write enable for the lane selects, active low |
| lane_sel_n | input | LANES | Per-lane write selects, active low |
| glob_wr_n | input | 1 | Global write of all lanes, active low |
| wdata | input | LANES*LANE_W | Write data |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| sleep | input | 1 | Sleep: freeze state and turn the outputs off, asynchronous |
| order_ilv | input | 1 | Burst order: 0 linear, 1 interleaved, static |
| dq_out | output | LANES*LANE_W | Flow-through read data, 0 when not driven |
| dq_drive | output | 1 | High when the read data is driven (models output enable of a tri-state bus) |

## Verification
The hardest case to reach from the ports is a write on a continuation edge: it must land on the freshly advanced beat and leave the burst base untouched. The bench gets there by starting a read burst with the processor strobe and then applying the global write together with an advance. It then restarts on the base with a read-only controller start to show that the base is unchanged. A second hard case is a processor strobe that arrives while the chip enable is inactive in the middle of a live burst. The bench raises the enable, pulses the strobe with a different address, and checks that the output still shows the old word. Both burst orders are swept over all 256 base addresses against a reference array that the bench fills with computed patterns.

// File: rtl/ftb_pkg.sv
package ftb_pkg;
  typedef enum logic [2:0] {
    K_CONT   = 3'd0,
    K_CPU    = 3'd1,
    K_CTL    = 3'd2,
    K_DESEL  = 3'd3,
    K_SLEEP  = 3'd4
  } cyc_kind_t;
endpackage

// File: rtl/ftb_rst_sync.sv
module ftb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/ftb_ctl.sv
module ftb_ctl
  import ftb_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             ce_n,
  input  logic             cpu_start_n,
  input  logic             ctl_start_n,
  input  logic             adv_n,
  input  logic             sleep,
  input  logic             sel_q,
  input  logic             wr_en_n,
  input  logic             glob_wr_n,
  input  logic [LANES-1:0] lane_sel_n,
  output logic             load,
  output logic             advance,
  output logic             sel_en,
  output logic             sel_d,
  output logic [LANES-1:0] we_mask
);
  cyc_kind_t kind;
  logic      wr_allow;

  // Cycle classification: sleep freezes, processor strobe wins when enabled.
  always_comb begin
    kind = K_CONT;
    if (sleep)                         kind = K_SLEEP;
    else if (!ce_n && !cpu_start_n)    kind = K_CPU;
    else if (!ctl_start_n)             kind = ce_n ? K_DESEL : K_CTL;
  end

  always_comb begin
    load     = (kind == K_CPU) || (kind == K_CTL);
    advance  = (kind == K_CONT) && !adv_n;
    sel_en   = load || (kind == K_DESEL);
    sel_d    = load;
    wr_allow = (kind == K_CTL) || ((kind == K_CONT) && sel_q);
  end

  // Lane write mask: global write covers every lane.
  always_comb begin
    we_mask = '0;
    if (wr_allow) begin
      if (!glob_wr_n)    we_mask = '1;
      else if (!wr_en_n) we_mask = ~lane_sel_n;
    end
  end
endmodule

// File: rtl/ftb_burst_addr.sv
module ftb_burst_addr #(
  parameter int ADDR_W = 8,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              advance,
  input  logic              order_ilv,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] next_addr
);
  logic [ADDR_W-1:0] base_q, base_d;
  logic [BEAT_W-1:0] cnt_q, cnt_d;
  logic              en;

  function automatic logic [BEAT_W-1:0] beat_low(
    input logic [BEAT_W-1:0] b,
    input logic [BEAT_W-1:0] c,
    input logic              ilv
  );
    return ilv ? (b ^ c) : BEAT_W'(b + c);
  endfunction

  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    if (load) begin
      base_d = ext_addr;
      cnt_d  = '0;
    end else if (advance) begin
      cnt_d  = BEAT_W'(cnt_q + 1'b1);
    end
    en = load || advance;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (en) begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

  assign cur_addr  = {base_q[ADDR_W-1:BEAT_W], beat_low(base_q[BEAT_W-1:0], cnt_q, order_ilv)};
  assign next_addr = {base_d[ADDR_W-1:BEAT_W], beat_low(base_d[BEAT_W-1:0], cnt_d, order_ilv)};
endmodule

// File: rtl/ftb_array.sv
module ftb_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        we_mask,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we_mask[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
  end
endmodule

// File: rtl/fts_burst_sram.sv
module fts_burst_sram #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int BEAT_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    ce_n,
  input  logic                    cpu_start_n,
  input  logic                    ctl_start_n,
  input  logic                    adv_n,
  input  logic                    wr_en_n,
  input  logic [LANES-1:0]        lane_sel_n,
  input  logic                    glob_wr_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    oe_n,
  input  logic                    sleep,
  input  logic                    order_ilv,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_drive
);
  localparam int DATA_W = LANES * LANE_W;

  logic              rst_sync_n;
  logic              load, advance, sel_en, sel_d;
  logic              sel_q;
  logic [LANES-1:0]  we_mask;
  logic [ADDR_W-1:0] cur_addr, next_addr;
  logic [DATA_W-1:0] rdata;

  ftb_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ftb_ctl #(.LANES(LANES)) u_ctl (
    .ce_n        (ce_n),
    .cpu_start_n (cpu_start_n),
    .ctl_start_n (ctl_start_n),
    .adv_n       (adv_n),
    .sleep       (sleep),
    .sel_q       (sel_q),
    .wr_en_n     (wr_en_n),
    .glob_wr_n   (glob_wr_n),
    .lane_sel_n  (lane_sel_n),
    .load        (load),
    .advance     (advance),
    .sel_en      (sel_en),
    .sel_d       (sel_d),
    .we_mask     (we_mask)
  );

  ftb_burst_addr #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load      (load),
    .advance   (advance),
    .order_ilv (order_ilv),
    .ext_addr  (addr),
    .cur_addr  (cur_addr),
    .next_addr (next_addr)
  );

  ftb_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk     (clk),
    .we_mask (we_mask),
    .waddr   (next_addr),
    .wdata   (wdata),
    .raddr   (cur_addr),
    .rdata   (rdata)
  );

  // Selection register: set by a burst start, cleared by a deselect.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  sel_q <= 1'b0;
    else if (sel_en)  sel_q <= sel_d;
  end

  assign dq_drive = sel_q && !oe_n && !sleep;
  assign dq_out   = dq_drive ? rdata : '0;
endmodule

// File: rtl/ftb_chk.sv
module ftb_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sleep,
  input logic              ce_n,
  input logic              cpu_start_n,
  input logic              ctl_start_n,
  input logic              adv_n,
  input logic              oe_n,
  input logic              order_ilv,
  input logic [ADDR_W-1:0] addr,
  input logic [ADDR_W-1:0] cur_addr,
  input logic              sel_q,
  input logic              dq_drive
);
  // R2: processor strobe loads the external address and selects.
  a_r2_cpu_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !ce_n && !cpu_start_n) |=> (cur_addr == $past(addr)) && sel_q);

  // R3: processor strobe with chip enable inactive changes nothing.
  a_r3_ce_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && ce_n && !cpu_start_n && ctl_start_n && adv_n) |=> $stable(cur_addr) && $stable(sel_q));

  // R4: controller strobe loads the external address when enabled.
  a_r4_ctl_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !ce_n && cpu_start_n && !ctl_start_n) |=> (cur_addr == $past(addr)) && sel_q);

  // R5: linear advance steps the low bits by one, upper bits fixed.
  a_r5_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !adv_n && cpu_start_n && ctl_start_n && !order_ilv) |=>
      order_ilv || ((cur_addr[1:0] == 2'($past(cur_addr[1:0]) + 2'd1)) &&
                    (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2]))));

  // R7: no advance and no start holds the address.
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && adv_n && cpu_start_n && ctl_start_n && $stable(order_ilv)) |=> $stable(cur_addr));

  // R11: output enable gates the drive.
  a_r11_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_drive);

  // R12: deselect turns the output off after one edge.
  a_r12_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && ce_n && !ctl_start_n) |=> !dq_drive && !sel_q);

  // R13: sleep freezes the burst state.
  a_r13_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && $stable(order_ilv)) |=> $stable(cur_addr) && $stable(sel_q));
endmodule

bind fts_burst_sram ftb_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .sleep       (sleep),
  .ce_n        (ce_n),
  .cpu_start_n (cpu_start_n),
  .ctl_start_n (ctl_start_n),
  .adv_n       (adv_n),
  .oe_n        (oe_n),
  .order_ilv   (order_ilv),
  .addr        (addr),
  .cur_addr    (cur_addr),
  .sel_q       (sel_q),
  .dq_drive    (dq_drive)
);

// File: tb/fts_burst_sram_tb.sv
module fts_burst_sram_tb;
  localparam int AW = 8;
  localparam int LN = 4;
  localparam int LW = 9;
  localparam int DW = LN * LW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          ce_n, cpu_start_n, ctl_start_n, adv_n, wr_en_n, glob_wr_n;
  logic [LN-1:0] lane_sel_n;
  logic [DW-1:0] wdata;
  logic          oe_n, sleep, order_ilv;
  logic [DW-1:0] dq_out;
  logic          dq_drive;

  logic [DW-1:0] refm [DEPTH];
  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #4 clk = ~clk;

  fts_burst_sram u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n),
    .cpu_start_n(cpu_start_n), .ctl_start_n(ctl_start_n), .adv_n(adv_n),
    .wr_en_n(wr_en_n), .lane_sel_n(lane_sel_n), .glob_wr_n(glob_wr_n),
    .wdata(wdata), .oe_n(oe_n), .sleep(sleep), .order_ilv(order_ilv),
    .dq_out(dq_out), .dq_drive(dq_drive)
  );

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    ce_n = 1'b0; cpu_start_n = 1'b1; ctl_start_n = 1'b1; adv_n = 1'b1;
    wr_en_n = 1'b1; lane_sel_n = '1; glob_wr_n = 1'b1; oe_n = 1'b0; sleep = 1'b0;
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  function automatic logic [DW-1:0] pat(input int a);
    return DW'(a * 12345) ^ 36'h5A5A5A5A5;
  endfunction

  function automatic int lin_a(input int b, input int k);
    return (b & ~3) | ((b + k) & 3);
  endfunction

  function automatic int ilv_a(input int b, input int k);
    return (b & ~3) | ((b ^ k) & 3);
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 60000) begin
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 60000);
        summary();
        $finish;
      end
    end
  end

  initial begin
    logic [DW-1:0] e, w, old;
    idle(); order_ilv = 1'b0; addr = '0; wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    chk(!dq_drive && dq_out == '0, "R1 reset deselected", dq_out, '0);
    rst_n = 1'b1;
    repeat (3) tick();
    chk(!dq_drive && dq_out == '0, "R1 after release", dq_out, '0);

    // Fill with global writes through the controller strobe.
    for (int a = 0; a < DEPTH; a++) begin
      idle(); addr = AW'(a); ctl_start_n = 1'b0; glob_wr_n = 1'b0;
      wr_en_n = 1'b1; lane_sel_n = '1; wdata = pat(a);
      tick();
      refm[a] = pat(a);
      chk(dq_drive && dq_out == pat(a), "R9 R4 R11 global write flow-through", dq_out, pat(a));
    end

    // Linear bursts over every base; processor strobe ignores write controls.
    order_ilv = 1'b0;
    for (int b = 0; b < DEPTH; b++) begin
      idle(); addr = AW'(b); cpu_start_n = 1'b0; wr_en_n = 1'b0; lane_sel_n = '0;
      glob_wr_n = 1'b0; wdata = ~pat(b);
      tick();
      chk(dq_out == refm[b], "R2 cpu start read", dq_out, refm[b]);
      for (int k = 1; k <= 4; k++) begin
        idle(); adv_n = 1'b0;
        tick();
        e = refm[lin_a(b, k)];
        chk(dq_out == e, "R5 linear beat", dq_out, e);
      end
    end

    // Interleaved bursts over every base via read-only controller starts.
    idle(); order_ilv = 1'b1;
    for (int b = 0; b < DEPTH; b++) begin
      idle(); addr = AW'(b); ctl_start_n = 1'b0;
      tick();
      chk(dq_out == refm[b], "R4 ctl start read", dq_out, refm[b]);
      for (int k = 1; k <= 4; k++) begin
        idle(); adv_n = 1'b0;
        tick();
        e = refm[ilv_a(b, k & 3)];
        chk(dq_out == e, "R6 interleaved beat", dq_out, e);
      end
    end
    idle(); order_ilv = 1'b0;

    // R7 hold without advance, and start overriding advance.
    idle(); addr = 8'd9; cpu_start_n = 1'b0; tick();
    for (int i = 0; i < 3; i++) begin
      idle(); tick();
      chk(dq_out == refm[9], "R7 hold without advance", dq_out, refm[9]);
    end
    idle(); addr = 8'd14; cpu_start_n = 1'b0; adv_n = 1'b0; tick();
    chk(dq_out == refm[14], "R7 start beats advance", dq_out, refm[14]);

    // R8 every lane-select pattern.
    for (int m = 0; m < 16; m++) begin
      logic [3:0] mm;
      mm = 4'(m);
      old = refm[64 + m];
      w = DW'(m * 977) ^ 36'h3C3C3C3C3;
      idle(); addr = AW'(64 + m); ctl_start_n = 1'b0; wr_en_n = 1'b0;
      lane_sel_n = ~mm; wdata = w;
      tick();
      e = old;
      for (int l = 0; l < LN; l++) if (mm[l]) e[l*LW +: LW] = w[l*LW +: LW];
      refm[64 + m] = e;
      chk(dq_out == e, "R8 lane write", dq_out, e);
    end
    idle(); addr = 8'd100; ctl_start_n = 1'b0; lane_sel_n = '0; wr_en_n = 1'b1;
    wdata = ~refm[100]; tick();
    chk(dq_out == refm[100], "R8 no write without enable", dq_out, refm[100]);

    // R10 continuation write lands on the advanced beat.
    idle(); addr = 8'd120; cpu_start_n = 1'b0; tick();
    w = 36'hABCDE1234;
    idle(); adv_n = 1'b0; glob_wr_n = 1'b0; wdata = w; tick();
    refm[121] = w;
    chk(dq_out == w, "R10 write on advanced beat", dq_out, w);
    idle(); addr = 8'd120; ctl_start_n = 1'b0; tick();
    chk(dq_out == refm[120], "R10 base untouched", dq_out, refm[120]);
    w = 36'h1FF0FF0FF;
    idle(); wr_en_n = 1'b0; lane_sel_n = 4'b1110; wdata = w; tick();
    refm[120][LW-1:0] = w[LW-1:0];
    chk(dq_out == refm[120], "R10 held-beat lane write", dq_out, refm[120]);
    idle(); addr = 8'd121; ctl_start_n = 1'b0; tick();
    chk(dq_out == refm[121], "R10 neighbour kept", dq_out, refm[121]);

    // R3 processor strobe blocked by chip enable.
    idle(); ce_n = 1'b1; cpu_start_n = 1'b0; addr = 8'd200; tick();
    chk(dq_drive && dq_out == refm[121], "R3 blocked strobe", dq_out, refm[121]);

    // R11 asynchronous output enable.
    idle(); oe_n = 1'b1; #1;
    chk(!dq_drive && dq_out == '0, "R11 oe off", dq_out, '0);
    oe_n = 1'b0; #1;
    chk(dq_drive && dq_out == refm[121], "R11 oe on", dq_out, refm[121]);

    // R12 single-cycle deselect.
    idle(); ce_n = 1'b1; ctl_start_n = 1'b0; #1;
    chk(dq_drive, "R12 driven before edge", {35'd0, dq_drive}, 36'd1);
    tick();
    chk(!dq_drive && dq_out == '0, "R12 off after edge", dq_out, '0);
    idle(); tick();
    chk(!dq_drive, "R12 stays off", {35'd0, dq_drive}, 36'd0);
    idle(); addr = 8'd5; ctl_start_n = 1'b0; tick();
    chk(dq_drive && dq_out == refm[5], "R12 reselect", dq_out, refm[5]);

    // R13 sleep freezes state and blocks writes.
    idle(); sleep = 1'b1; ctl_start_n = 1'b0; addr = 8'd6; glob_wr_n = 1'b0;
    wdata = ~refm[6]; #1;
    chk(!dq_drive && dq_out == '0, "R13 sleep output off", dq_out, '0);
    tick(); adv_n = 1'b0; tick();
    chk(!dq_drive, "R13 off during sleep", {35'd0, dq_drive}, 36'd0);
    idle(); #1;
    chk(dq_drive && dq_out == refm[5], "R13 address retained", dq_out, refm[5]);
    idle(); addr = 8'd6; ctl_start_n = 1'b0; tick();
    chk(dq_out == refm[6], "R13 no write in sleep", dq_out, refm[6]);

    summary();
    $finish;
  end
endmodule